// File: doc/BRIEF.md
# Digital Segment LCD Driver

This block drives a multiplexed segment LCD panel using nothing but two-level digital outputs. It scans up to eight common lines, one per time slot, and drives up to twenty-eight segment lines. Each segment has a display word with one bit per common; a set bit means that segment is lit while that common is active. No intermediate bias voltages are generated. The panel sees either a correlated square-wave pattern or pulse-width-modulated levels, and it integrates these into an RMS voltage.

Software writes display words into a buffer. At every frame boundary the buffer is copied into a shadow that feeds the waveform logic, so a partly updated picture is never shown. The polarity of every output flips on alternate frames, which keeps the average voltage across each segment at zero. The `frame_pol` output doubles as the frame clock. Two drive methods can be selected: correlation, where an unlit segment follows the active common in phase, and PWM, where an unlit segment is driven against its common for a programmable part of each slot.

Top module: `lcd_seg_drv`

## Requirements
- R1: After reset, and on the first clock edge with `enable` low, `frame_pol` is 0. While `enable` is low, every bit of `com_o` and `seg_o` is 0.
- R2: A slot lasts 16×CLK_DIV clocks and is made of 16 steps of CLK_DIV clocks each. Commons are scanned in slot order 0,1,…,N−1, where N = `mux_sel`+1. During its slot the active common drives the level of `frame_pol`.
- R3: A common whose index is N or higher is held at 0.
- R4: Within the first N commons, a common that is not active drives `frame_pol` XOR (bit 0 of the step number), so it toggles every CLK_DIV clocks.
- R5: `frame_pol` is 0 in the first frame after enabling. It inverts after every N slots, and only at a slot boundary.
- R6: With `drive_mode`=0 (correlation), during slot k a segment drives the inverse of `frame_pol` when bit k of its display word is 1, and drives `frame_pol` when that bit is 0. A segment output does not change inside a slot.
- R7: With `drive_mode`=1 (PWM), a lit segment drives the inverse of `frame_pol` for the whole slot. An unlit segment drives the inverse of `frame_pol` during steps 0 to `pwm_duty`−1 and drives `frame_pol` during the remaining steps. A duty of 0 therefore matches correlation behaviour for unlit segments.
- R8: When `wr_en` is high, `wr_data` is written as the display word of segment `wr_addr`, with bit k belonging to common k. The word becomes visible at the next frame boundary. A write sampled on the last clock of a frame shows only from the frame after next. While the block is disabled, the shadow follows the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the scan; when low, outputs are 0 and timing restarts |
| drive_mode | input | 1 | 0 = correlation, 1 = PWM |
| mux_sel | input | 3 | Number of commons in use, minus one |
| pwm_duty | input | 4 | Number of steps an unlit segment is driven against its common in PWM mode |
| wr_en | input | 1 | Write strobe for the display buffer |
| wr_addr | input | 5 | Segment index of the word being written |
| wr_data | input | 8 | Display word, one bit per common |
| com_o | output | 8 | Common line drive |
| seg_o | output | 28 | Segment line drive |
| frame_pol | output | 1 | Frame polarity, also used as the frame clock |

## Verification
Two things can occur on the same clock edge: a buffer write and the shadow copy that happens at a frame boundary. In that case the shadow must take the old word. The bench places a write exactly on the last clock of a frame and checks that the old segment pattern is still shown throughout the following frame and that the new pattern appears one frame later. A second write, placed in the middle of a frame, is checked to stay hidden for the rest of that frame and to appear in the next one.

// File: rtl/lcd_seg_pkg.sv
package lcd_seg_pkg;
   typedef enum logic {
      DRV_CORR = 1'b0,
      DRV_PWM  = 1'b1
   } drive_mode_e;
endpackage

// File: rtl/lcd_seg_timebase.sv
module lcd_seg_timebase #(
   parameter int NUM_COM = 8,
   parameter int CLK_DIV = 4,
   parameter int DUTY_W  = 4,
   localparam int COM_W  = $clog2(NUM_COM)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [COM_W-1:0]  mux_sel,
   output logic [DUTY_W-1:0] step,
   output logic [COM_W-1:0]  slot,
   output logic              pol,
   output logic              frame_end
);
   localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
   localparam logic [DUTY_W-1:0] STEP_LAST = '1;

   logic tick;

   generate
      if (CLK_DIV > 1) begin : g_div
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         div_q <= '0;
            else if (!en || tick)               div_q <= '0;
            else                                div_q <= div_q + 1'b1;
         end
         assign tick = (div_q == DIV_W'(CLK_DIV - 1));
      end else begin : g_nodiv
         assign tick = 1'b1;
      end
   endgenerate

   assign frame_end = en && tick && (step == STEP_LAST) && (slot >= mux_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step <= '0;
         slot <= '0;
         pol  <= 1'b0;
      end else if (!en) begin
         step <= '0;
         slot <= '0;
         pol  <= 1'b0;
      end else if (tick) begin
         step <= step + 1'b1;
         if (step == STEP_LAST) begin
            if (slot >= mux_sel) begin
               slot <= '0;
               pol  <= ~pol;
            end else begin
               slot <= slot + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/lcd_seg_buffer.sv
module lcd_seg_buffer #(
   parameter int NUM_COM = 8,
   parameter int NUM_SEG = 28,
   localparam int SEG_W  = $clog2(NUM_SEG)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [SEG_W-1:0]                  wr_addr,
   input  logic [NUM_COM-1:0]                wr_data,
   input  logic                              load,
   output logic [NUM_SEG-1:0][NUM_COM-1:0]   shadow_o
);
   logic [NUM_SEG-1:0][NUM_COM-1:0] words_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         words_q <= '0;
      end else if (wr_en && (32'(wr_addr) < NUM_SEG)) begin
         words_q[wr_addr] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    shadow_o <= '0;
      else if (load) shadow_o <= words_q;
   end
endmodule

// File: rtl/lcd_seg_wave.sv
module lcd_seg_wave
   import lcd_seg_pkg::*;
#(
   parameter int NUM_COM = 8,
   parameter int NUM_SEG = 28,
   parameter int DUTY_W  = 4,
   localparam int COM_W  = $clog2(NUM_COM)
) (
   input  logic                             en,
   input  drive_mode_e                      mode,
   input  logic [COM_W-1:0]                 mux_sel,
   input  logic [DUTY_W-1:0]                duty,
   input  logic [DUTY_W-1:0]                step,
   input  logic [COM_W-1:0]                 slot,
   input  logic                             pol,
   input  logic [NUM_SEG-1:0][NUM_COM-1:0]  shadow,
   output logic [NUM_COM-1:0]               com_o,
   output logic [NUM_SEG-1:0]               seg_o
);
   logic unlit_against;
   logic idle_com;

   assign unlit_against = (mode == DRV_PWM) && (step < duty);
   assign idle_com      = pol ^ step[0];

   generate
      for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
         logic lit;
         assign lit      = shadow[s][slot];
         assign seg_o[s] = en & ((lit | unlit_against) ? ~pol : pol);
      end
      for (genvar c = 0; c < NUM_COM; c++) begin : g_com
         logic used;
         assign used     = (COM_W'(c) <= mux_sel);
         assign com_o[c] = en & used & ((slot == COM_W'(c)) ? pol : idle_com);
      end
   endgenerate
endmodule

// File: rtl/lcd_seg_drv.sv
module lcd_seg_drv
   import lcd_seg_pkg::*;
#(
   parameter int NUM_COM = 8,
   parameter int NUM_SEG = 28,
   parameter int CLK_DIV = 4,
   parameter int DUTY_W  = 4,
   localparam int COM_W  = $clog2(NUM_COM),
   localparam int SEG_W  = $clog2(NUM_SEG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               drive_mode,
   input  logic [COM_W-1:0]   mux_sel,
   input  logic [DUTY_W-1:0]  pwm_duty,
   input  logic               wr_en,
   input  logic [SEG_W-1:0]   wr_addr,
   input  logic [NUM_COM-1:0] wr_data,
   output logic [NUM_COM-1:0] com_o,
   output logic [NUM_SEG-1:0] seg_o,
   output logic               frame_pol
);
   generate
      if (NUM_COM < 2 || NUM_COM > 8 || (NUM_COM & (NUM_COM - 1)) != 0) begin : g_bad_com
         $error("NUM_COM must be 2, 4 or 8");
      end
      if (NUM_SEG < 2 || NUM_SEG > 64) begin : g_bad_seg
         $error("NUM_SEG must be 2..64");
      end
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
      if (DUTY_W < 1 || DUTY_W > 8) begin : g_bad_duty
         $error("DUTY_W must be 1..8");
      end
   endgenerate

   logic [DUTY_W-1:0]               step;
   logic [COM_W-1:0]                slot;
   logic                            frame_end;
   logic [NUM_SEG-1:0][NUM_COM-1:0] shadow;

   lcd_seg_timebase #(
      .NUM_COM (NUM_COM),
      .CLK_DIV (CLK_DIV),
      .DUTY_W  (DUTY_W)
   ) i_timebase (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (enable),
      .mux_sel   (mux_sel),
      .step      (step),
      .slot      (slot),
      .pol       (frame_pol),
      .frame_end (frame_end)
   );

   lcd_seg_buffer #(
      .NUM_COM (NUM_COM),
      .NUM_SEG (NUM_SEG)
   ) i_buffer (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .load     (frame_end | ~enable),
      .shadow_o (shadow)
   );

   lcd_seg_wave #(
      .NUM_COM (NUM_COM),
      .NUM_SEG (NUM_SEG),
      .DUTY_W  (DUTY_W)
   ) i_wave (
      .en      (enable),
      .mode    (drive_mode_e'(drive_mode)),
      .mux_sel (mux_sel),
      .duty    (pwm_duty),
      .step    (step),
      .slot    (slot),
      .pol     (frame_pol),
      .shadow  (shadow),
      .com_o   (com_o),
      .seg_o   (seg_o)
   );
endmodule

// File: rtl/lcd_seg_chk.sv
module lcd_seg_chk #(
   parameter int NUM_COM = 8,
   parameter int NUM_SEG = 28,
   parameter int CLK_DIV = 4,
   parameter int DUTY_W  = 4,
   localparam int COM_W  = $clog2(NUM_COM)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               enable,
   input logic               drive_mode,
   input logic [COM_W-1:0]   mux_sel,
   input logic [NUM_COM-1:0] com_o,
   input logic [NUM_SEG-1:0] seg_o,
   input logic               frame_pol
);
   localparam int SLOT_LEN = CLK_DIV * (2 ** DUTY_W);

   int unsigned          slot_cnt;
   logic [NUM_COM:0]     used_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          slot_cnt <= 0;
      else if (!enable)                    slot_cnt <= 0;
      else if (slot_cnt == SLOT_LEN - 1)   slot_cnt <= 0;
      else                                 slot_cnt <= slot_cnt + 1;
   end

   assign used_mask = ((NUM_COM + 1)'(1) << (32'(mux_sel) + 1)) - 1'b1;

   AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (com_o == '0) && (seg_o == '0)); // R1

   AST_UNUSED_COM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      enable |-> ((com_o & ~used_mask[NUM_COM-1:0]) == '0)); // R3

   AST_POL_AT_SLOT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable) && (frame_pol != $past(frame_pol))) |-> (slot_cnt == 0)); // R5

   AST_CORR_SEG_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable) && (slot_cnt != 0) && !drive_mode && !$past(drive_mode)
       && $stable(mux_sel)) |-> $stable(seg_o)); // R6
endmodule

bind lcd_seg_drv lcd_seg_chk #(
   .NUM_COM (NUM_COM),
   .NUM_SEG (NUM_SEG),
   .CLK_DIV (CLK_DIV),
   .DUTY_W  (DUTY_W)
) i_lcd_seg_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .drive_mode (drive_mode),
   .mux_sel    (mux_sel),
   .com_o      (com_o),
   .seg_o      (seg_o),
   .frame_pol  (frame_pol)
);

// File: tb/test_lcd_seg_drv.sv
module test_lcd_seg_drv;
   localparam int NC   = 8;
   localparam int NS   = 28;
   localparam int DIV  = 2;
   localparam int SL   = DIV * 16;
   localparam int NROW = 12;

   // row: {mode[19], mux[18:16], duty[15:12], j[11:0]}
   localparam logic [19:0] VEC [NROW] = '{
      {1'b0, 3'd7, 4'd0,  12'd0},
      {1'b0, 3'd7, 4'd0,  12'd33},
      {1'b0, 3'd7, 4'd0,  12'd255},
      {1'b0, 3'd7, 4'd0,  12'd256},
      {1'b0, 3'd2, 4'd0,  12'd70},
      {1'b0, 3'd0, 4'd0,  12'd40},
      {1'b1, 3'd3, 4'd5,  12'd9},
      {1'b1, 3'd3, 4'd5,  12'd10},
      {1'b1, 3'd3, 4'd0,  12'd3},
      {1'b1, 3'd3, 4'd15, 12'd29},
      {1'b1, 3'd3, 4'd15, 12'd31},
      {1'b1, 3'd5, 4'd8,  12'd200}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic          drive_mode = 1'b0;
   logic [2:0]    mux_sel = '0;
   logic [3:0]    pwm_duty = '0;
   logic          wr_en = 1'b0;
   logic [4:0]    wr_addr = '0;
   logic [NC-1:0] wr_data = '0;
   logic [NC-1:0] com_o;
   logic [NS-1:0] seg_o;
   logic          frame_pol;

   int            checks = 0;
   int            errors = 0;
   int            ecount = 0;
   logic [NC-1:0] pat_now [NS];

   always #10 clk = ~clk;

   always @(posedge clk) ecount <= enable ? ecount + 1 : 0;

   lcd_seg_drv #(.NUM_COM(NC), .NUM_SEG(NS), .CLK_DIV(DIV), .DUTY_W(4)) i_lcd_seg_drv (
      .clk(clk), .rst_n(rst_n), .enable(enable), .drive_mode(drive_mode),
      .mux_sel(mux_sel), .pwm_duty(pwm_duty), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .com_o(com_o), .seg_o(seg_o), .frame_pol(frame_pol)
   );

   function automatic logic [NC-1:0] pat(int s);
      return NC'((s * 37) ^ 8'h5A);
   endfunction

   function automatic logic exp_pol(int j, int mux);
      return 1'((j / ((mux + 1) * SL)) & 1);
   endfunction

   function automatic logic [NC-1:0] exp_com(int j, int mux);
      logic [NC-1:0] r;
      int fl = (mux + 1) * SL;
      int k  = (j % fl) / SL;
      int st = (j % SL) / DIV;
      logic p = exp_pol(j, mux);
      r = '0;
      for (int c = 0; c < NC; c++) begin
         if (c > mux)       r[c] = 1'b0;
         else if (c == k)   r[c] = p;
         else               r[c] = p ^ 1'(st & 1);
      end
      return r;
   endfunction

   function automatic logic [NS-1:0] exp_seg(int j, int mux, logic mode, int duty);
      logic [NS-1:0] r;
      int fl = (mux + 1) * SL;
      int k  = (j % fl) / SL;
      int st = (j % SL) / DIV;
      logic p = exp_pol(j, mux);
      for (int s = 0; s < NS; s++) begin
         if (pat_now[s][k])              r[s] = ~p;
         else if (mode && (st < duty))   r[s] = ~p;
         else                            r[s] = p;
      end
      return r;
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(int s, logic [NC-1:0] d);
      wr_en = 1'b1; wr_addr = 5'(s); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_j(int j);
      while (ecount != j) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [NC-1:0] new0;
      logic [NC-1:0] new1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset com", 64'(com_o), 64'(0));
      chk("R1 reset seg", 64'(seg_o), 64'(0));
      chk("R1 reset pol", 64'(frame_pol), 64'(0));

      for (int s = 0; s < NS; s++) begin
         wr(s, pat(s));
         pat_now[s] = pat(s);
      end
      repeat (2) @(negedge clk);

      for (int r = 0; r < NROW; r++) begin
         logic m;
         int mx, du, j;
         m  = VEC[r][19];
         mx = int'(VEC[r][18:16]);
         du = int'(VEC[r][15:12]);
         j  = int'(VEC[r][11:0]);
         enable = 1'b0;
         @(negedge clk);
         drive_mode = m; mux_sel = 3'(mx); pwm_duty = 4'(du); enable = 1'b1;
         wait_j(j);
         #1;
         chk("R2/R3/R4 commons", 64'(com_o), 64'(exp_com(j, mx)));
         chk(m ? "R7 pwm segments" : "R6 corr segments", 64'(seg_o), 64'(exp_seg(j, mx, m, du)));
         chk("R5 frame polarity", 64'(frame_pol), 64'(exp_pol(j, mx)));
      end

      // R8: mid-frame write and write on the last clock of a frame
      new0 = ~pat(0);
      new1 = ~pat(1);
      enable = 1'b0;
      @(negedge clk);
      drive_mode = 1'b0; mux_sel = 3'd1; pwm_duty = 4'd0; enable = 1'b1;
      wait_j(10);
      wr(0, new0);
      wait_j(20);
      chk("R8 mid-frame write hidden", 64'(seg_o), 64'(exp_seg(20, 1, 1'b0, 0)));
      wait_j(65);
      pat_now[0] = new0;
      chk("R8 mid-frame write shown next frame", 64'(seg_o), 64'(exp_seg(65, 1, 1'b0, 0)));
      wait_j(127);
      wr(1, new1);
      wait_j(129);
      chk("R8 boundary write hidden one frame", 64'(seg_o), 64'(exp_seg(129, 1, 1'b0, 0)));
      wait_j(193);
      pat_now[1] = new1;
      chk("R8 boundary write shown after", 64'(seg_o), 64'(exp_seg(193, 1, 1'b0, 0)));

      // R1: dropping enable while running with frame_pol high
      chk("R5 polarity odd frame", 64'(frame_pol), 64'(1));
      enable = 1'b0;
      #1;
      chk("R1 disable com low", 64'(com_o), 64'(0));
      chk("R1 disable seg low", 64'(seg_o), 64'(0));
      @(negedge clk);
      chk("R1 disable pol low", 64'(frame_pol), 64'(0));

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule